// File: doc/BRIEF.md
# RS485 Transmit-Direction RTS Driver

This block produces the level of a UART's RTS pin. In the default mode the pin simply mirrors the RTS value held in the modem-control logic, as an RS232 port expects. When the RS485 mode bit is set, the pin is no longer under software control. It instead steers the driver-enable input of an external half-duplex RS485 transceiver, and it follows what the transmitter is doing.

In RS485 mode the transmitter counts as busy while its shift register is active or while its holding register or FIFO still holds data. While it is busy the pin is raised. Once the last stop bit of the last queued character has left the shift register, the pin drops. The pin also stays raised across the short gap between back-to-back characters, as long as data remains queued. An invert bit flips this automatic level for transceivers whose enable is active low. The invert bit is ignored in RS232 mode. The pin comes from a flop, so combinational hazards on the status inputs never reach the transceiver.

Top module: `rs485_rts_dir`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released (before any input has taken effect), the pin `rtsPin` is 0.
- R2: With `rs485En` = 0, `rtsPin` equals the value `modemRts` had at the previous rising clock edge.
- R3: With `rs485En` = 0, `autoInvert`, `shiftBusy` and `queueNotEmpty` have no effect on `rtsPin`.
- R4: With `rs485En` = 1 and `autoInvert` = 0, `rtsPin` is 1 one cycle after any cycle in which `shiftBusy` = 1 or `queueNotEmpty` = 1.
- R5: With `rs485En` = 1 and `autoInvert` = 0, `rtsPin` is 0 one cycle after a cycle in which both `shiftBusy` and `queueNotEmpty` are 0, whatever `modemRts` is.
- R6: With `rs485En` = 1 and `autoInvert` = 1, the automatic level is reversed. `rtsPin` is 0 after an active cycle and 1 after an idle cycle.
- R7: `rtsPin` changes only at a rising clock edge. An input change between edges does not show on the pin until the next edge.
- R8: In RS485 mode, a gap in `shiftBusy` between characters does not release the pin while `queueNotEmpty` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rs485En | input | 1 | 1 selects automatic RS485 direction control, 0 selects RS232 |
| autoInvert | input | 1 | Reverses the automatic level (RS485 mode only) |
| modemRts | input | 1 | RTS value from modem control, used in RS232 mode |
| shiftBusy | input | 1 | Transmit shift register is sending a character |
| queueNotEmpty | input | 1 | Holding register or transmit FIFO holds data |
| rtsPin | output | 1 | Registered RTS pin level |

## Verification
The output is a single flop behind a small select. A wrong mode decision or a wrong polarity therefore shows on `rtsPin` in the very next cycle, as a pin at the opposite level. Random mixes of all five inputs catch any cross-term that should be masked, such as the invert bit leaking into RS232 mode or `modemRts` leaking into RS485 mode. Directed sequences cover the inter-character gap and changes made between clock edges, where a path that bypasses the flop would show up early.

// File: rtl/rs485_rts_pkg.sv
package rs485_rts_pkg;

  // Strobes from the control decode to the output datapath
  typedef struct packed {
    logic useAuto;    // 1: pin takes the automatic level
    logic autoLevel;  // automatic level after polarity
  } rtsStrobe_t;

  localparam logic RTS_RESET_LEVEL = 1'b0;

endpackage

// File: rtl/rs485_rts_ctl.sv
module rs485_rts_ctl
  import rs485_rts_pkg::*;
(
  input  logic       rs485En,
  input  logic       autoInvert,
  input  logic       shiftBusy,
  input  logic       queueNotEmpty,
  output rtsStrobe_t strobe
);

  logic txActive;

  // Busy from the first load until the queue is empty and the last stop bit is out
  assign txActive = shiftBusy | queueNotEmpty;

  always_comb begin
    strobe.useAuto   = rs485En;
    strobe.autoLevel = txActive ^ autoInvert;
  end

endmodule

// File: rtl/rs485_rts_dp.sv
module rs485_rts_dp
  import rs485_rts_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rtsStrobe_t strobe,
  input  logic       modemRts,
  output logic       rtsPin
);

  logic rtsNext;

  always_comb begin
    rtsNext = strobe.useAuto ? strobe.autoLevel : modemRts;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsPin <= RTS_RESET_LEVEL;
    else       rtsPin <= rtsNext;
  end

endmodule

// File: rtl/rs485_rts_dir.sv
module rs485_rts_dir
  import rs485_rts_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rs485En,
  input  logic autoInvert,
  input  logic modemRts,
  input  logic shiftBusy,
  input  logic queueNotEmpty,
  output logic rtsPin
);

  rtsStrobe_t strobe;

  rs485_rts_ctl u_ctl (
    .rs485En      (rs485En),
    .autoInvert   (autoInvert),
    .shiftBusy    (shiftBusy),
    .queueNotEmpty(queueNotEmpty),
    .strobe       (strobe)
  );

  rs485_rts_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .modemRts(modemRts),
    .rtsPin  (rtsPin)
  );

  // One clock seen since reset, so $past refers to post-reset values
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  always_comb begin
    if (!rstN) AST_RESET_LOW: assert (rtsPin == 1'b0); // R1
  end

  AST_RS232_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(rs485En)) |-> (rtsPin == $past(modemRts))); // R2

  AST_AUTO_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rs485En) && !$past(autoInvert) &&
     ($past(shiftBusy) || $past(queueNotEmpty))) |-> rtsPin); // R4

  AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rs485En) && !$past(autoInvert) &&
     !$past(shiftBusy) && !$past(queueNotEmpty)) |-> !rtsPin); // R5

  AST_AUTO_INVERT: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rs485En) && $past(autoInvert)) |->
      (rtsPin != ($past(shiftBusy) || $past(queueNotEmpty)))); // R6

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rs485En) && !$past(autoInvert) && $past(queueNotEmpty))
      |-> rtsPin); // R8

endmodule

// File: tb/sim_rs485_rts_dir.sv
module sim_rs485_rts_dir;

  localparam time CLK_PERIOD = 10ns;
  localparam int  RAND_CYCLES = 3000;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rs485En = 1'b0, autoInvert = 1'b0, modemRts = 1'b0;
  logic shiftBusy = 1'b0, queueNotEmpty = 1'b0;
  logic rtsPin;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic expNext;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_rts_dir u0 (
    .clk(clk), .rstN(rstN), .rs485En(rs485En), .autoInvert(autoInvert),
    .modemRts(modemRts), .shiftBusy(shiftBusy), .queueNotEmpty(queueNotEmpty),
    .rtsPin(rtsPin)
  );

  function automatic logic expRts(logic en, logic inv, logic mcr, logic busy, logic q);
    if (!en) return mcr;
    return (busy | q) ^ inv;
  endfunction

  function automatic string tagFor(logic en, logic inv, logic busy, logic q);
    if (!en) return "R2";
    if (inv) return "R6";
    if (busy | q) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: rtsPin=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, remember expectation for next edge
  task automatic drive(logic en, logic inv, logic mcr, logic busy, logic q);
    @(negedge clk);
    rs485En = en; autoInvert = inv; modemRts = mcr;
    shiftBusy = busy; queueNotEmpty = q;
    expNext = expRts(en, inv, mcr, busy, q);
  endtask

  task automatic stepCheck(string tag);
    @(posedge clk); #1;
    check(tag, rtsPin, expNext);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      miscompares++;
      $display("FAIL watchdog: rtsPin=%b expected=finish", rtsPin);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic prev;
    void'($urandom(32'd4851));
    // R1: reset state, with inputs that would otherwise raise the pin
    modemRts = 1'b1; shiftBusy = 1'b1;
    #(CLK_PERIOD*3);
    check("R1", rtsPin, 1'b0);
    @(negedge clk); rstN = 1'b1;
    check("R1", rtsPin, 1'b0);

    // R2: RS232 follows modem value
    drive(0, 0, 1, 0, 0); stepCheck("R2");
    drive(0, 0, 0, 1, 1); stepCheck("R3");   // R3 status ignored
    drive(0, 1, 0, 1, 0); stepCheck("R3");   // R3 invert ignored
    drive(0, 1, 1, 0, 0); stepCheck("R3");

    // R4 / R5 automatic mode, modem value opposite
    drive(1, 0, 0, 1, 0); stepCheck("R4");
    drive(1, 0, 0, 0, 1); stepCheck("R4");
    drive(1, 0, 1, 0, 0); stepCheck("R5");

    // R8: back-to-back characters, shift gap while queue holds data
    drive(1, 0, 0, 1, 1); stepCheck("R8");
    drive(1, 0, 0, 0, 1); stepCheck("R8");
    drive(1, 0, 0, 1, 1); stepCheck("R8");
    drive(1, 0, 0, 1, 0); stepCheck("R8");
    drive(1, 0, 0, 0, 0); stepCheck("R5");

    // R6: inverted polarity
    drive(1, 1, 1, 1, 0); stepCheck("R6");
    drive(1, 1, 0, 0, 0); stepCheck("R6");
    drive(1, 1, 0, 0, 1); stepCheck("R6");

    // R7: mid-cycle change does not reach the pin before the edge
    drive(1, 0, 0, 0, 0); stepCheck("R5");
    @(negedge clk);
    prev = rtsPin;
    shiftBusy = 1'b1;
    #1; check("R7", rtsPin, prev);
    rs485En = 1'b0; modemRts = 1'b1;
    #1; check("R7", rtsPin, prev);
    expNext = 1'b1;
    stepCheck("R7");

    // Random mix
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic en, inv, mcr, busy, q;
      en = 1'($urandom); inv = 1'($urandom); mcr = 1'($urandom);
      busy = 1'($urandom); q = (($urandom % 4) == 0);
      drive(en, inv, mcr, busy, q);
      stepCheck(tagFor(en, inv, busy, q));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule